// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-channel datapath of a legacy-compatible DMA controller. Software programs a 16-bit low address, an 8-bit page, an optional 8-bit high page and a 16-bit count that holds the number of transfers minus one. Each time the arbiter reports that one bus transfer has completed, the engine moves the physical address forward by one transfer unit and counts the count down. When the count runs out, it raises a one-cycle terminal-count pulse. A channel runs either in byte mode, with 64 KB pages, or in word mode, with 128 KB pages and even addresses. In word mode the low address register holds physical bits 16:1 and bit 0 of the page is unused.

Without a high-page write, the low address wraps inside its page. Writing the high page, which is the last step of setup, enables a carry from the low address into the page and from the page into the high page. The host sees the remaining work as a residue equal to the count plus one, modulo 2^16. This residue reads zero once the transfer has completed.

The control is a three-state machine. In CH_MASKED, transfer strobes are ignored and the `unmask` strobe takes the machine to CH_ACTIVE (transition ARM). In CH_ACTIVE, a transfer strobe that finds the count at zero takes the machine to CH_TERMINAL (transition FINISH). CH_TERMINAL lasts exactly one cycle and drives the terminal-count pulse. From there, auto-init returns the machine to CH_ACTIVE and reloads the base copies (transition REARM). Without auto-init the machine goes to CH_MASKED (transition PARK).

Top module: `dma_chan_engine`

## Requirements
- R1: In byte mode (cfg_word=0), bus_addr = {high page, page[7:0], low[15:0]}.
- R2: In word mode (cfg_word=1), bus_addr = {high page, page[7:1], low[15:0], 1'b0}: page bit 0 is ignored and bus_addr bit 0 is always 0.
- R3: While carry is disabled, the low address wraps within its page on a transfer and neither the page nor the high page changes. Carry is disabled after reset and after a page write.
- R4: A high-page write loads bus_addr[31:24] and enables carry. With carry enabled, a low-address wrap increments the page (page[7:1] in word mode), and a page wrap increments the high page.
- R5: A loaded count N gives exactly N+1 accepted transfers before terminal count. N=0xFFFF gives 65536 transfers, and each accepted transfer lowers the count by one.
- R6: residue = count + 1 modulo 2^16. It reads 0 in the terminal-count cycle, and it reads 1 after reset.
- R7: tc_pulse is high for exactly one cycle: the cycle after the edge that accepted the final transfer.
- R8: After terminal count with cfg_autoinit=1, the channel stays unmasked and the address, page, high page and count reload from the values last written. With cfg_autoinit=0, the channel becomes masked.
- R9: While masked, xfer_done has no effect. The unmask strobe arms the channel.
- R10: After reset, the channel is masked, bus_addr is 0, tc_pulse is 0 and residue is 1.
- R11: A register write in the same cycle as an accepted transfer takes priority for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 1 | 1 = word channel, 0 = byte channel |
| cfg_autoinit | input | 1 | Reload base values at terminal count |
| unmask | input | 1 | Strobe: arm a masked channel |
| wr_addr | input | 1 | Strobe: write base and current low address |
| wdata_addr | input | 16 | Low address data |
| wr_cnt | input | 1 | Strobe: write base and current count |
| wdata_cnt | input | 16 | Count data (transfers minus one) |
| wr_page | input | 1 | Strobe: write page, disable carry |
| wdata_page | input | 8 | Page data |
| wr_hpage | input | 1 | Strobe: write high page, enable carry |
| wdata_hpage | input | 8 | High-page data |
| xfer_done | input | 1 | One transfer completed |
| bus_addr | output | 32 | Physical address of the next transfer |
| tc_pulse | output | 1 | Terminal-count pulse |
| residue | output | 16 | Count plus one, modulo 2^16 |
| masked | output | 1 | Channel mask bit |

## Verification
A wrong carry-enable flag or page register shows up at bus_addr on the first transfer that wraps the low address: the page either moves when it should hold or holds when it should move. An off-by-one in the count shows up as a terminal pulse one transfer early or late, and as a residue that differs from the expected value on every cycle after the count was loaded. A wrong state shows within one cycle on masked or tc_pulse. A wrong reload shows in the first cycle after the terminal pulse. The bench holds a behavioural reference and compares all four outputs on every clock, so any divergence is reported in the cycle where it first becomes visible.

// File: rtl/dce_pkg.sv
package dce_pkg;
    typedef enum logic [1:0] {
        CH_MASKED   = 2'd0,
        CH_ACTIVE   = 2'd1,
        CH_TERMINAL = 2'd2
    } ch_state_e;
endpackage

// File: rtl/dce_ctrl.sv
module dce_ctrl
    import dce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic unmask,
    input  logic xfer_done,
    input  logic cnt_zero,
    input  logic cfg_autoinit,
    output logic fire,
    output logic reload,
    output logic tc_pulse,
    output logic masked
);
    ch_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_MASKED;
        else        state_q <= state_d;
    end

    // transitions: ARM, FINISH, REARM, PARK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_MASKED:   if (unmask) state_d = CH_ACTIVE;
            CH_ACTIVE:   if (xfer_done && cnt_zero) state_d = CH_TERMINAL;
            CH_TERMINAL: state_d = cfg_autoinit ? CH_ACTIVE : CH_MASKED;
            default:     state_d = CH_MASKED;
        endcase
    end

    // outputs
    always_comb begin
        fire     = 1'b0;
        reload   = 1'b0;
        tc_pulse = 1'b0;
        masked   = 1'b0;
        unique case (state_q)
            CH_MASKED:   masked = 1'b1;
            CH_ACTIVE:   fire = xfer_done;
            CH_TERMINAL: begin
                tc_pulse = 1'b1;
                reload   = cfg_autoinit;
            end
            default:     masked = 1'b1;
        endcase
    end

    // R7
    tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);
    // R8
    tc_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !cfg_autoinit) |=> masked);
    // R8
    tc_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && cfg_autoinit) |=> !masked);
    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !unmask) |=> masked);
    // R9
    masked_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        masked |-> !fire);
endmodule

// File: rtl/dce_count.sv
module dce_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wdata_cnt,
    input  logic             fire,
    input  logic             reload,
    output logic             cnt_zero,
    output logic [CNT_W-1:0] residue
);
    logic [CNT_W-1:0] cur_q, base_q, cur_d;

    always_comb begin
        if (wr_cnt)      cur_d = wdata_cnt;
        else if (reload) cur_d = base_q;
        else if (fire)   cur_d = cur_q - CNT_W'(1);
        else             cur_d = cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            base_q <= '0;
        end else begin
            cur_q <= cur_d;
            if (wr_cnt) base_q <= wdata_cnt;
        end
    end

    assign cnt_zero = (cur_q == '0);
    assign residue  = cur_q + CNT_W'(1);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_cnt && !reload) |=> residue == $past(residue) - CNT_W'(1));
    // R6
    count_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cnt_zero && !wr_cnt) |=> residue == '0);
endmodule

// File: rtl/dce_addr.sv
module dce_addr #(
    parameter int LOW_W    = 16,
    parameter int PAGE_W   = 8,
    parameter int HPG_W    = 8,
    parameter bit HPAGE_EN = 1'b1,
    localparam int PHYS_W  = HPG_W + PAGE_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_word,
    input  logic              wr_addr,
    input  logic [LOW_W-1:0]  wdata_addr,
    input  logic              wr_page,
    input  logic [PAGE_W-1:0] wdata_page,
    input  logic              wr_hpage,
    input  logic [HPG_W-1:0]  wdata_hpage,
    input  logic              fire,
    input  logic              reload,
    output logic [PHYS_W-1:0] bus_addr
);
    logic [LOW_W-1:0]  low_q, low_base, low_d;
    logic [PAGE_W-1:0] page_q, page_base, page_d;
    logic [HPG_W-1:0]  hpg_q;
    logic              hp_en_q;

    logic              low_cy;
    logic [LOW_W-1:0]  low_inc;
    logic [PAGE_W:0]   pg_b_sum;
    logic [PAGE_W-1:0] pg_w_sum;
    logic [PAGE_W-1:0] page_adv;
    logic              pg_cy;
    logic              carry_pg;

    assign {low_cy, low_inc} = {1'b0, low_q} + (LOW_W+1)'(1);
    assign pg_b_sum = {1'b0, page_q} + (PAGE_W+1)'(1);
    assign pg_w_sum = {1'b0, page_q[PAGE_W-1:1]} + PAGE_W'(1);
    assign page_adv = cfg_word ? {pg_w_sum[PAGE_W-2:0], page_q[0]} : pg_b_sum[PAGE_W-1:0];
    assign pg_cy    = cfg_word ? pg_w_sum[PAGE_W-1] : pg_b_sum[PAGE_W];
    assign carry_pg = hp_en_q && low_cy;

    always_comb begin
        if (wr_addr)     low_d = wdata_addr;
        else if (reload) low_d = low_base;
        else if (fire)   low_d = low_inc;
        else             low_d = low_q;
    end

    always_comb begin
        if (wr_page)               page_d = wdata_page;
        else if (reload)           page_d = page_base;
        else if (fire && carry_pg) page_d = page_adv;
        else                       page_d = page_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q     <= '0;
            low_base  <= '0;
            page_q    <= '0;
            page_base <= '0;
        end else begin
            low_q  <= low_d;
            page_q <= page_d;
            if (wr_addr) low_base  <= wdata_addr;
            if (wr_page) page_base <= wdata_page;
        end
    end

    generate
        if (HPAGE_EN) begin : g_hpage
            logic [HPG_W-1:0] hpg_r, hpg_base, hpg_d;
            logic             en_r;
            always_comb begin
                if (wr_hpage)                       hpg_d = wdata_hpage;
                else if (reload)                    hpg_d = hpg_base;
                else if (fire && carry_pg && pg_cy) hpg_d = hpg_r + HPG_W'(1);
                else                                hpg_d = hpg_r;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hpg_r    <= '0;
                    hpg_base <= '0;
                    en_r     <= 1'b0;
                end else begin
                    hpg_r <= hpg_d;
                    if (wr_hpage) begin
                        hpg_base <= wdata_hpage;
                        en_r     <= 1'b1;
                    end else if (wr_page) begin
                        en_r <= 1'b0;
                    end
                end
            end
            assign hpg_q   = hpg_r;
            assign hp_en_q = en_r;
        end else begin : g_nohpage
            assign hpg_q   = '0;
            assign hp_en_q = 1'b0;
        end
    endgenerate

    assign bus_addr = cfg_word ? {hpg_q, page_q[PAGE_W-1:1], low_q, 1'b0}
                               : {hpg_q, page_q, low_q};

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hp_en_q && !wr_page && !wr_hpage && !reload)
        |=> ($stable(page_q) && $stable(hpg_q)));
    // R2
    word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word |-> (bus_addr[0] == 1'b0));
    // R4
    page_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && hp_en_q && !cfg_word && (&low_q) && !wr_page && !wr_hpage && !reload)
        |=> page_q == PAGE_W'($past(page_q) + 1'b1));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
    parameter int LOW_W    = 16,
    parameter int PAGE_W   = 8,
    parameter int HPG_W    = 8,
    parameter int CNT_W    = 16,
    parameter bit HPAGE_EN = 1'b1,
    localparam int PHYS_W  = HPG_W + PAGE_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_word,
    input  logic              cfg_autoinit,
    input  logic              unmask,
    input  logic              wr_addr,
    input  logic [LOW_W-1:0]  wdata_addr,
    input  logic              wr_cnt,
    input  logic [CNT_W-1:0]  wdata_cnt,
    input  logic              wr_page,
    input  logic [PAGE_W-1:0] wdata_page,
    input  logic              wr_hpage,
    input  logic [HPG_W-1:0]  wdata_hpage,
    input  logic              xfer_done,
    output logic [PHYS_W-1:0] bus_addr,
    output logic              tc_pulse,
    output logic [CNT_W-1:0]  residue,
    output logic              masked
);
    logic fire, reload, cnt_zero;

    dce_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .unmask       (unmask),
        .xfer_done    (xfer_done),
        .cnt_zero     (cnt_zero),
        .cfg_autoinit (cfg_autoinit),
        .fire         (fire),
        .reload       (reload),
        .tc_pulse     (tc_pulse),
        .masked       (masked)
    );

    dce_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cnt    (wr_cnt),
        .wdata_cnt (wdata_cnt),
        .fire      (fire),
        .reload    (reload),
        .cnt_zero  (cnt_zero),
        .residue   (residue)
    );

    dce_addr #(
        .LOW_W    (LOW_W),
        .PAGE_W   (PAGE_W),
        .HPG_W    (HPG_W),
        .HPAGE_EN (HPAGE_EN)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_word    (cfg_word),
        .wr_addr     (wr_addr),
        .wdata_addr  (wdata_addr),
        .wr_page     (wr_page),
        .wdata_page  (wdata_page),
        .wr_hpage    (wr_hpage),
        .wdata_hpage (wdata_hpage),
        .fire        (fire),
        .reload      (reload),
        .bus_addr    (bus_addr)
    );

    // R6
    tc_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !$past(wr_cnt)) |-> residue == '0);
endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_word = 1'b0, cfg_autoinit = 1'b0, unmask = 1'b0;
    logic        wr_addr = 1'b0, wr_cnt = 1'b0, wr_page = 1'b0, wr_hpage = 1'b0;
    logic [15:0] wdata_addr = '0, wdata_cnt = '0;
    logic [7:0]  wdata_page = '0, wdata_hpage = '0;
    logic        xfer_done = 1'b0;
    logic [31:0] bus_addr;
    logic        tc_pulse, masked;
    logic [15:0] residue;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R10";
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    dma_chan_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_autoinit(cfg_autoinit),
        .unmask(unmask), .wr_addr(wr_addr), .wdata_addr(wdata_addr),
        .wr_cnt(wr_cnt), .wdata_cnt(wdata_cnt), .wr_page(wr_page),
        .wdata_page(wdata_page), .wr_hpage(wr_hpage), .wdata_hpage(wdata_hpage),
        .xfer_done(xfer_done), .bus_addr(bus_addr), .tc_pulse(tc_pulse),
        .residue(residue), .masked(masked)
    );

    // behavioural reference: 0 masked, 1 active, 2 terminal
    int          m_st;
    logic [15:0] m_low, m_blow, m_cnt, m_bcnt, a_low;
    logic [7:0]  m_page, m_bpage, m_hp, m_bhp, a_page, a_hp;
    logic        m_hpen, f, rl;
    logic [31:0] phys;
    int          n_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_low = 0; m_blow = 0; m_cnt = 0; m_bcnt = 0;
            m_page = 0; m_bpage = 0; m_hp = 0; m_bhp = 0; m_hpen = 0;
        end else begin
            f  = (m_st == 1) && xfer_done;
            rl = (m_st == 2) && cfg_autoinit;
            n_st = m_st;
            if (m_st == 0 && unmask) n_st = 1;
            if (m_st == 1 && f && m_cnt == 0) n_st = 2;
            if (m_st == 2) n_st = cfg_autoinit ? 1 : 0;
            if (!cfg_word) begin
                if (m_hpen) phys = {m_hp, m_page, m_low} + 32'd1;
                else        phys = {m_hp, m_page, m_low + 16'd1};
                a_low = phys[15:0]; a_page = phys[23:16]; a_hp = phys[31:24];
            end else begin
                if (m_hpen) phys = {m_hp, m_page[7:1], m_low, 1'b0} + 32'd2;
                else        phys = {m_hp, m_page[7:1], m_low + 16'd1, 1'b0};
                a_low = phys[16:1]; a_page = {phys[23:17], m_page[0]}; a_hp = phys[31:24];
            end
            if (wr_addr) begin m_blow = wdata_addr; m_low = wdata_addr; end
            else if (rl) m_low = m_blow;
            else if (f)  m_low = a_low;
            if (wr_page) begin m_bpage = wdata_page; m_page = wdata_page; end
            else if (rl) m_page = m_bpage;
            else if (f)  m_page = a_page;
            if (wr_hpage) begin m_bhp = wdata_hpage; m_hp = wdata_hpage; end
            else if (rl) m_hp = m_bhp;
            else if (f)  m_hp = a_hp;
            if (wr_hpage)     m_hpen = 1'b1;
            else if (wr_page) m_hpen = 1'b0;
            if (wr_cnt) begin m_bcnt = wdata_cnt; m_cnt = wdata_cnt; end
            else if (rl) m_cnt = m_bcnt;
            else if (f)  m_cnt = m_cnt - 16'd1;
            m_st = n_st;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk({cur_req, " bus_addr"}, bus_addr,
                cfg_word ? {m_hp, m_page[7:1], m_low, 1'b0} : {m_hp, m_page, m_low});
            chk({cur_req, " tc_pulse"}, {31'd0, tc_pulse}, {31'd0, m_st == 2});
            chk({cur_req, " residue"}, {16'd0, residue}, {16'd0, m_cnt + 16'd1});
            chk({cur_req, " masked"}, {31'd0, masked}, {31'd0, m_st == 0});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
        unmask = 0; wr_addr = 0; wr_cnt = 0; wr_page = 0; wr_hpage = 0; xfer_done = 0;
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] p, input logic [15:0] c);
        wr_addr = 1; wdata_addr = a; wr_page = 1; wdata_page = p; wr_cnt = 1; wdata_cnt = c;
        idle(1);
    endtask

    task automatic hpage(input logic [7:0] h);
        wr_hpage = 1; wdata_hpage = h; idle(1);
    endtask

    task automatic xfer(input int n);
        xfer_done = 1; idle(n);
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk("R10 addr", bus_addr, 32'h0);
        chk("R10 masked", {31'd0, masked}, 32'd1);
        chk("R10 tc", {31'd0, tc_pulse}, 32'd0);
        chk("R6 reset residue", {16'd0, residue}, 32'd1);

        // byte channel, carry disabled
        cur_req = "R3";
        @(posedge clk); #2;
        prog(16'hFFFE, 8'h12, 16'd3);
        @(negedge clk); chk("R1 byte map", bus_addr, 32'h0012FFFE);
        cur_req = "R9";
        xfer(3);
        @(negedge clk); chk("R9 masked ignore addr", bus_addr, 32'h0012FFFE);
        chk("R9 masked ignore residue", {16'd0, residue}, 32'd4);
        unmask = 1; idle(1);
        cur_req = "R3";
        xfer(2);
        @(negedge clk); chk("R3 wrap in page", bus_addr, 32'h00120000);
        cur_req = "R7";
        xfer(2);
        @(negedge clk); chk("R7 tc high", {31'd0, tc_pulse}, 32'd1);
        chk("R6 done residue", {16'd0, residue}, 32'd0);
        chk("R5 final addr", bus_addr, 32'h00120002);
        idle(1);
        @(negedge clk); chk("R7 tc one cycle", {31'd0, tc_pulse}, 32'd0);
        chk("R8 parked", {31'd0, masked}, 32'd1);

        // byte channel, carry enabled
        cur_req = "R4";
        prog(16'hFFFF, 8'hFF, 16'd1);
        hpage(8'h05);
        @(negedge clk); chk("R4 high page", bus_addr, 32'h05FFFFFF);
        unmask = 1; idle(1);
        xfer(1);
        @(negedge clk); chk("R4 carry into high page", bus_addr, 32'h06000000);
        xfer(1); idle(2);

        // word channel, carry disabled by page write
        cur_req = "R2";
        cfg_word = 1;
        prog(16'hFFFF, 8'h13, 16'd2);
        @(negedge clk); chk("R2 word map", bus_addr, 32'h0613FFFE);
        unmask = 1; idle(1);
        xfer(1);
        @(negedge clk); chk("R3 word wrap", bus_addr, 32'h06120000);
        xfer(2); idle(2);

        // write priority over an accepted transfer
        cur_req = "R11";
        wr_cnt = 1; wdata_cnt = 16'd5; idle(1);
        unmask = 1; idle(1);
        xfer_done = 1; wr_cnt = 1; wdata_cnt = 16'h0010; idle(1);
        @(negedge clk); chk("R11 write wins", {16'd0, residue}, 32'h11);

        // auto-init on a byte channel
        cur_req = "R8";
        cfg_word = 0; cfg_autoinit = 1;
        prog(16'h1000, 8'h20, 16'd1);
        hpage(8'h00);
        xfer(2);
        @(negedge clk); chk("R8 tc before reload", {31'd0, tc_pulse}, 32'd1);
        idle(1);
        @(negedge clk); chk("R8 reload addr", bus_addr, 32'h00201000);
        chk("R8 reload count", {16'd0, residue}, 32'd2);
        chk("R8 stays armed", {31'd0, masked}, 32'd0);
        cfg_autoinit = 0;

        // full 65536-word run with carry
        cur_req = "R5";
        cfg_word = 1;
        prog(16'h0000, 8'h00, 16'hFFFF);
        hpage(8'h00);
        xfer(65535);
        @(negedge clk); chk("R5 not yet done", {31'd0, tc_pulse}, 32'd0);
        chk("R5 one left", {16'd0, residue}, 32'd1);
        xfer(1);
        @(negedge clk); chk("R5 tc after 65536", {31'd0, tc_pulse}, 32'd1);
        chk("R4 word page carry", bus_addr, 32'h00020000);
        idle(2);

        // word channel carry into high page
        cur_req = "R4";
        prog(16'hFFFF, 8'hFF, 16'd0);
        hpage(8'h7F);
        @(negedge clk); chk("R2 word top", bus_addr, 32'h7FFFFFFE);
        unmask = 1; idle(1);
        xfer(1);
        @(negedge clk); chk("R4 word high carry", bus_addr, 32'h80000000);
        idle(3);
        summary();
    end
endmodule